// File: doc/BRIEF.md
# Threshold Alert and Status Flag Controller

This block sits beside a measurement engine that produces a shunt voltage, a bus voltage and a power word at the end of each conversion cycle. It owns a 16-bit alert control register and a 16-bit threshold register. Both are reached through a simple register port. After each completed conversion it compares one chosen result against the threshold. It also keeps status flags for the alert function, for conversion completion and for arithmetic overflow, and it drives a single alert output level whose active sense is programmable.

Five compare functions can be enabled. When several are enabled, only the one in the most significant enabled position is evaluated. A conversion-ready alert can be enabled at the same time. The alert function flag has two clearing modes. In latched mode it holds until the control register is read. In follow mode it drops at the first later conversion that does not trip the compare. The analog front end, the averaging and the serial transport belong to other blocks. The output pad is modelled as a logic level only.

Top module: `alrt_flag_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000, the threshold register reads 0x0000, and `alert_pin` is 1.
- R2: `reg_sel`=0 addresses the control register and `reg_sel`=1 addresses the threshold register. A write to the control register updates only bits 15..10, bit 1 and bit 0. Bits 9..5 always read 0. Writes to bits 4..2 are ignored. The threshold register takes all 16 written bits.
- R3: Bits 15..11 enable, from bit 15 down: shunt above threshold, shunt below threshold, bus above threshold, bus below threshold, power above threshold. When several of these bits are set, only the function of the highest set bit is evaluated. When none is set, no conversion trips the compare.
- R4: "Above" means strictly greater and "below" means strictly less. Equality never trips. Shunt comparisons are two's-complement signed. Bus and power comparisons are unsigned.
- R5: A `conv_done` pulse that trips the selected compare sets bit 4 (alert function flag). The flag is visible one cycle after the pulse.
- R6: Every `conv_done` pulse sets bit 3 (conversion-ready flag) one cycle later. When `single_shot`=1, bit 3 clears on a control-register read (`reg_rd` with `reg_sel`=0). It also clears on a `cfg_wr` with `cfg_idle_sel`=0. A `cfg_wr` with `cfg_idle_sel`=1 leaves it unchanged. When `single_shot`=0, neither event clears it. A `conv_done` in the same cycle as a clearing event wins.
- R7: On each `conv_done`, bit 2 (overflow flag) takes the value of `math_ovf`.
- R8: With bit 0 = 1 (latched), bit 4 stays set through later conversions that do not trip. It clears on a control-register read. A tripping conversion in the same cycle as that read keeps it set. The read returns the value from before the clear.
- R9: With bit 0 = 0 (follow), bit 4 clears on the next conversion that does not trip, and a control-register read leaves it unchanged.
- R10: The alert is active when bit 4 is set, or when both bit 10 and bit 3 are set. With bit 1 = 0, `alert_pin` is 0 when the alert is active and 1 otherwise. With bit 1 = 1 the sense is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle pulse: result words and overflow are valid |
| shunt_res | input | 16 | Shunt voltage result, signed |
| bus_res | input | 16 | Bus voltage result, unsigned |
| pwr_res | input | 16 | Power result, unsigned |
| math_ovf | input | 1 | Arithmetic overflow for this conversion |
| single_shot | input | 1 | Engine runs in triggered single-conversion mode |
| cfg_wr | input | 1 | Pulse: engine configuration register written |
| cfg_idle_sel | input | 1 | That configuration write selects power-down or disable |
| reg_sel | input | 1 | 0 = control register, 1 = threshold register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the register selected by `reg_sel` |
| alert_pin | output | 1 | Alert output level |

## Verification
Every flag and every stored register bit changes at the first rising edge after the strobe that causes it. Read data and `alert_pin` follow the stored state combinationally. A read therefore returns the state from before its own side effect. The bench drives each strobe for exactly one cycle from the falling edge. It samples at the next falling edge, so exactly one register stage separates stimulus and check. Side-effect-free peeks (with `reg_rd` low) show the flags between steps.

// File: rtl/alrt_pkg.sv
package alrt_pkg;
  parameter int REG_W = 16;
  parameter int NFN   = 5;
  localparam int B_FN_LO = 11;
  localparam int B_CNVR  = 10;
  localparam int B_AFF   = 4;
  localparam int B_CVRF  = 3;
  localparam int B_OVF   = 2;
  localparam int B_POL   = 1;
  localparam int B_LEN   = 0;
  localparam int IDX_W   = $clog2(NFN);

  // index = bit position minus B_FN_LO; higher index wins
  localparam logic [IDX_W-1:0] FN_SH_ABOVE  = 4;
  localparam logic [IDX_W-1:0] FN_SH_BELOW  = 3;
  localparam logic [IDX_W-1:0] FN_BUS_ABOVE = 2;
  localparam logic [IDX_W-1:0] FN_BUS_BELOW = 1;
  localparam logic [IDX_W-1:0] FN_PWR_ABOVE = 0;

  function automatic logic fn_trips(input logic [IDX_W-1:0] idx,
                                    input logic [REG_W-1:0] sh,
                                    input logic [REG_W-1:0] bu,
                                    input logic [REG_W-1:0] pw,
                                    input logic [REG_W-1:0] lim);
    logic r;
    case (idx)
      FN_SH_ABOVE:  r = $signed(sh) > $signed(lim);
      FN_SH_BELOW:  r = $signed(sh) < $signed(lim);
      FN_BUS_ABOVE: r = bu > lim;
      FN_BUS_BELOW: r = bu < lim;
      FN_PWR_ABOVE: r = pw > lim;
      default:      r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [NFN-1:0] top_enable(input logic [NFN-1:0] en);
    logic [NFN-1:0] m;
    logic seen;
    m = '0;
    seen = 1'b0;
    for (int i = NFN - 1; i >= 0; i--) begin
      if (en[i] && !seen) begin
        m[i] = 1'b1;
        seen = 1'b1;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/alrt_ctl_reg.sv
module alrt_ctl_reg
  import alrt_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctl,
  input  logic           wr_lim,
  input  logic [W-1:0]   wdata,
  output logic [NFN-1:0] fn_en,
  output logic           cnvr_en,
  output logic           pol,
  output logic           len,
  output logic [W-1:0]   lim
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_en   <= '0;
      cnvr_en <= 1'b0;
      pol     <= 1'b0;
      len     <= 1'b0;
      lim     <= '0;
    end else begin
      if (wr_ctl) begin
        fn_en   <= wdata[B_FN_LO +: NFN];
        cnvr_en <= wdata[B_CNVR];
        pol     <= wdata[B_POL];
        len     <= wdata[B_LEN];
      end
      if (wr_lim) lim <= wdata;
    end
  end
endmodule

// File: rtl/alrt_sel_cmp.sv
module alrt_sel_cmp
  import alrt_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [NFN-1:0] fn_en,
  input  logic [W-1:0]   sh,
  input  logic [W-1:0]   bu,
  input  logic [W-1:0]   pw,
  input  logic [W-1:0]   lim,
  output logic           hit
);
  logic [NFN-1:0] raw;
  logic [NFN-1:0] keep;

  for (genvar g = 0; g < NFN; g++) begin : g_fn
    assign raw[g] = fn_trips(IDX_W'(g), sh, bu, pw, lim);
  end

  assign keep = top_enable(fn_en);
  assign hit  = |(raw & keep);
endmodule

// File: rtl/alrt_flag_reg.sv
module alrt_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  logic conv_hit,
  input  logic math_ovf,
  input  logic len,
  input  logic single_shot,
  input  logic ctl_rd,
  input  logic cfg_clr,
  output logic aff,
  output logic cvrf,
  output logic ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aff  <= 1'b0;
      cvrf <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (conv_done && conv_hit)   aff <= 1'b1;
      else if (conv_done && !len)  aff <= 1'b0;
      else if (ctl_rd && len)      aff <= 1'b0;

      if (conv_done)                              cvrf <= 1'b1;
      else if (single_shot && (ctl_rd || cfg_clr)) cvrf <= 1'b0;

      if (conv_done) ovf <= math_ovf;
    end
  end
endmodule

// File: rtl/alrt_flag_ctrl.sv
module alrt_flag_ctrl
  import alrt_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_done,
  input  logic [W-1:0] shunt_res,
  input  logic [W-1:0] bus_res,
  input  logic [W-1:0] pwr_res,
  input  logic         math_ovf,
  input  logic         single_shot,
  input  logic         cfg_wr,
  input  logic         cfg_idle_sel,
  input  logic         reg_sel,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         alert_pin
);
  logic [NFN-1:0] fn_en;
  logic           cnvr_en, pol_q, len_q;
  logic [W-1:0]   lim;
  logic           conv_hit, aff_q, cvrf_q, ovf_q;
  logic           ctl_rd_evt, cfg_clr_evt, alert_act;
  logic [W-1:0]   ctl_word;

  assign ctl_rd_evt  = reg_rd && !reg_sel;
  assign cfg_clr_evt = cfg_wr && !cfg_idle_sel;

  alrt_ctl_reg #(.W(W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctl(reg_wr && !reg_sel), .wr_lim(reg_wr && reg_sel),
    .wdata(reg_wdata), .fn_en(fn_en), .cnvr_en(cnvr_en),
    .pol(pol_q), .len(len_q), .lim(lim)
  );

  alrt_sel_cmp #(.W(W)) u_cmp (
    .fn_en(fn_en), .sh(shunt_res), .bu(bus_res), .pw(pwr_res),
    .lim(lim), .hit(conv_hit)
  );

  alrt_flag_reg u_flg (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_hit(conv_hit),
    .math_ovf(math_ovf), .len(len_q), .single_shot(single_shot),
    .ctl_rd(ctl_rd_evt), .cfg_clr(cfg_clr_evt),
    .aff(aff_q), .cvrf(cvrf_q), .ovf(ovf_q)
  );

  always_comb begin
    ctl_word                    = '0;
    ctl_word[B_FN_LO +: NFN]    = fn_en;
    ctl_word[B_CNVR]            = cnvr_en;
    ctl_word[B_AFF]             = aff_q;
    ctl_word[B_CVRF]            = cvrf_q;
    ctl_word[B_OVF]             = ovf_q;
    ctl_word[B_POL]             = pol_q;
    ctl_word[B_LEN]             = len_q;
  end

  assign reg_rdata = reg_sel ? lim : ctl_word;
  assign alert_act = aff_q || (cnvr_en && cvrf_q);
  assign alert_pin = pol_q ? alert_act : !alert_act;
endmodule

// File: rtl/alrt_chk.sv
module alrt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        conv_done,
  input logic        conv_hit,
  input logic        aff_q,
  input logic        cvrf_q,
  input logic        len_q,
  input logic        pol_q,
  input logic        ctl_rd_evt,
  input logic        alert_pin,
  input logic        reg_sel,
  input logic [15:0] reg_rdata
);
  AST_TRIP_SETS_AFF: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && conv_hit |=> aff_q); // R5
  AST_CONV_SETS_CVRF: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> cvrf_q); // R6
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    len_q && aff_q && !ctl_rd_evt |=> aff_q); // R8
  AST_FOLLOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !len_q && conv_done && !conv_hit |=> !aff_q); // R9
  AST_AFF_DRIVES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    aff_q |-> alert_pin == pol_q); // R10
  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> reg_rdata[9:5] == 5'd0); // R2
endmodule

bind alrt_flag_ctrl alrt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_hit(conv_hit),
  .aff_q(aff_q), .cvrf_q(cvrf_q), .len_q(len_q), .pol_q(pol_q),
  .ctl_rd_evt(ctl_rd_evt), .alert_pin(alert_pin), .reg_sel(reg_sel),
  .reg_rdata(reg_rdata)
);

// File: tb/sim_alrt_flag_ctrl.sv
module sim_alrt_flag_ctrl;
  localparam int CLK_PER = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic conv_done = 0, math_ovf = 0, single_shot = 0, cfg_wr = 0, cfg_idle_sel = 0;
  logic reg_sel = 0, reg_wr = 0, reg_rd = 0;
  logic [15:0] shunt_res = 0, bus_res = 0, pwr_res = 0, reg_wdata = 0, reg_rdata;
  logic alert_pin;
  int errors = 0, checks = 0;

  // reference state
  logic [4:0] m_en = 0;
  logic m_cnvr = 0, m_pol = 0, m_len = 0, m_aff = 0, m_cvrf = 0, m_ovf = 0;
  logic [15:0] m_lim = 0;

  alrt_flag_ctrl u0 (.*);

  always #(CLK_PER/2) clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic ref_trip(input logic [4:0] en, input logic [15:0] sh,
                                    input logic [15:0] bu, input logic [15:0] pw,
                                    input logic [15:0] lim);
    int sv, lv;
    sv = int'($signed(sh));
    lv = int'($signed(lim));
    if (en[4]) return sv > lv;
    if (en[3]) return sv < lv;
    if (en[2]) return int'(bu) > int'(lim);
    if (en[1]) return int'(bu) < int'(lim);
    if (en[0]) return int'(pw) > int'(lim);
    return 1'b0;
  endfunction

  function automatic logic [15:0] ref_word();
    return {m_en, m_cnvr, 5'd0, m_aff, m_cvrf, m_ovf, m_pol, m_len};
  endfunction

  function automatic logic ref_pin();
    logic act;
    act = m_aff | (m_cnvr & m_cvrf);
    return m_pol ? act : ~act;
  endfunction

  task automatic peek(input string tag);
    reg_sel = 1'b0;
    #1;
    check({tag, " ctl"}, reg_rdata, ref_word());
    check({tag, " pin"}, {15'd0, alert_pin}, {15'd0, ref_pin()});
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (sel) m_lim = d;
    else begin m_en = d[15:11]; m_cnvr = d[10]; m_pol = d[1]; m_len = d[0]; end
  endtask

  task automatic conv(input logic [15:0] sh, input logic [15:0] bu,
                      input logic [15:0] pw, input logic ov);
    logic h;
    @(negedge clk);
    shunt_res = sh; bus_res = bu; pwr_res = pw; math_ovf = ov; conv_done = 1'b1;
    h = ref_trip(m_en, sh, bu, pw, m_lim);
    @(negedge clk);
    conv_done = 1'b0;
    m_cvrf = 1'b1; m_ovf = ov;
    if (h) m_aff = 1'b1; else if (!m_len) m_aff = 1'b0;
  endtask

  task automatic rd_ctl(input string tag);
    @(negedge clk);
    reg_sel = 1'b0; reg_rd = 1'b1;
    #1;
    check({tag, " read value"}, reg_rdata, ref_word());
    @(negedge clk);
    reg_rd = 1'b0;
    if (m_len) m_aff = 1'b0;
    if (single_shot) m_cvrf = 1'b0;
  endtask

  initial begin
    logic [15:0] vs [3], vb [3], vp [3];
    vs[0] = 16'hFF00; vb[0] = 16'h0200; vp[0] = 16'h0050;
    vs[1] = 16'h0200; vb[1] = 16'h0050; vp[1] = 16'h0300;
    vs[2] = 16'h0100; vb[2] = 16'h0100; vp[2] = 16'h0100;

    #(3*CLK_PER);
    reg_sel = 1'b1; #1;
    check("R1 reset threshold", reg_rdata, 16'h0000);
    reg_sel = 1'b0; #1;
    check("R1 reset ctl", reg_rdata, 16'h0000);
    check("R1 reset pin", {15'd0, alert_pin}, 16'h0001);
    @(negedge clk); rst_n = 1'b1;

    // R2: register masking
    wr(1'b0, 16'hFFFF);
    peek("R2 write all ones");
    reg_sel = 1'b0; #1;
    check("R2 gap and status bits", reg_rdata & 16'h03FC, 16'h0000);
    wr(1'b1, 16'hA5C3);
    reg_sel = 1'b1; #1;
    check("R2 threshold readback", reg_rdata, 16'hA5C3);
    wr(1'b0, 16'h0000);

    // R3/R4/R5/R8/R9/R10 sweep over every enable pattern, both modes
    wr(1'b1, 16'h0100);
    for (int l = 0; l < 2; l++) begin
      for (int e = 0; e < 32; e++) begin
        wr(1'b0, {e[4:0], 1'b0, 8'd0, e[0] ^ l[0], l[0]});
        for (int v = 0; v < 3; v++) begin
          conv(vs[v], vb[v], vp[v], v[0]);
          peek($sformatf("R3 R4 R5 R7 R8 R9 R10 en=%0d len=%0d v=%0d", e, l, v));
        end
        rd_ctl("R8 R9 sweep read");
        peek("R8 R9 after read");
      end
    end

    // R4: signed threshold on shunt, unsigned on bus
    wr(1'b1, 16'hFF80);
    wr(1'b0, 16'h8000);
    conv(16'hFF90, 0, 0, 0); peek("R4 signed -112 above -128");
    conv(16'hFF00, 0, 0, 0); peek("R4 signed -256 not above -128");
    wr(1'b0, 16'h2000);
    conv(0, 16'h0100, 0, 0); peek("R4 unsigned bus 0x0100 not above 0xFF80");
    wr(1'b0, 16'h1000);
    conv(0, 16'h0100, 0, 0); peek("R4 unsigned bus below");

    // R8: read and tripping conversion in the same cycle keep the flag
    wr(1'b0, 16'h1001);
    conv(0, 16'h0000, 0, 0); peek("R8 latched trip");
    @(negedge clk);
    reg_sel = 1'b0; reg_rd = 1'b1; conv_done = 1'b1; bus_res = 16'h0000;
    @(negedge clk);
    reg_rd = 1'b0; conv_done = 1'b0;
    m_aff = 1'b1; m_cvrf = 1'b1;
    peek("R8 trip wins over read");

    // R6: conversion-ready flag clearing in single-shot and continuous modes
    wr(1'b0, 16'h0400);
    rd_ctl("R6 pre");
    single_shot = 1'b1;
    conv(0, 0, 0, 0); peek("R6 R10 ready alert active");
    @(negedge clk); cfg_wr = 1'b1; cfg_idle_sel = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; cfg_idle_sel = 1'b0;
    peek("R6 power-down config write keeps flag");
    @(negedge clk); cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; m_cvrf = 1'b0;
    peek("R6 config write clears flag");
    conv(0, 0, 0, 0);
    rd_ctl("R6 single-shot read"); peek("R6 read clears flag");
    single_shot = 1'b0;
    conv(0, 0, 0, 0);
    rd_ctl("R6 continuous read"); peek("R6 continuous read keeps flag");
    @(negedge clk); cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    peek("R6 continuous config write keeps flag");
    single_shot = 1'b1;
    @(negedge clk);
    reg_sel = 1'b0; reg_rd = 1'b1; conv_done = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; conv_done = 1'b0; m_cvrf = 1'b1; m_ovf = 1'b0;
    peek("R6 conversion wins over read");

    // R7: overflow follows each conversion
    conv(0, 0, 0, 1'b1); peek("R7 overflow set");
    conv(0, 0, 0, 1'b0); peek("R7 overflow cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule